// File: doc/BRIEF.md
# Serial EEPROM Read Controller

This block fetches 16-bit configuration words from a small three-wire serial EEPROM. The EEPROM has a chip select, a serial clock and a single data line. The controller makes the serial clock by dividing the system clock by a parameter, which defaults to 32. It drives a read instruction onto the data line: a start bit, the two-bit read code and the word address, most significant bit first. It then releases the line and ignores the dummy zero that the EEPROM returns. After that it shifts in the sixteen data bits, most significant bit first, and presents the word on a parallel output with a one-cycle valid strobe.

A client starts a read by raising `rd_req` with the address while `rd_ready` is high. `rd_ready` stays low from acceptance until the controller is back in its idle state. The controller only ever issues read instructions. Outgoing bits change on falling serial-clock edges, and incoming bits are captured on rising edges. Between two instructions, chip select stays low for at least one full serial-clock period.

The state machine has four states:
- IDLE: ready, with chip select, clock and data enable all low.
- SEND: chip select high and the instruction shifting out.
- RECV: data line released, dummy bit skipped and data shifting in.
- GAP: chip select low for one serial-clock period.

The transitions are:
- IDLE→SEND: on an accepted request.
- SEND→RECV: on the falling edge that follows the last address bit's rising edge.
- RECV→GAP: on the falling edge that follows the last data bit's rising edge.
- GAP→IDLE: when the divider wraps.

Top module: `sprom_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sclk`, `ee_do_oe` and `rd_valid` are 0, and `rd_ready` is 1.
- R2: `ee_sclk` is low whenever `ee_cs` is low. During a transaction its rising edges are DIV system cycles apart, and the first rising edge comes DIV/2 cycles after `ee_cs` rises.
- R3: `ee_cs` is high at every rising edge of `ee_sclk`, and it rises before the first one.
- R4: The instruction is 11 bits, MSB first: start bit 1, read code 1 then 0, then the 8 address bits MSB first. The start bit is on `ee_do` when `ee_cs` rises. Each later bit changes only together with a falling edge of `ee_sclk`.
- R5: `ee_do_oe` is 1 across the 11 instruction rising edges and 0 at every later rising edge. It is always 0 while `ee_cs` is low.
- R6: A transaction has exactly 28 rising edges. The 12th rising edge samples the dummy bit, which is discarded. The next 16 rising edges capture the data, MSB first, into `rd_data`.
- R7: `rd_valid` pulses for exactly one cycle, in the first cycle that `ee_cs` is low after a transaction. `rd_data` holds the word until the next transaction completes.
- R8: Between two transactions, `ee_cs` stays low for at least DIV system cycles.
- R9: `rd_ready` is 1 only in IDLE. A request is accepted only when `rd_req` and `rd_ready` are both 1. A request raised while busy starts no transaction and produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Word address, captured on acceptance |
| rd_ready | output | 1 | High when a request can be accepted |
| rd_data | output | DATA_W | Last word read |
| rd_valid | output | 1 | One-cycle strobe marking a new `rd_data` |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sclk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Outgoing value on the data line |
| ee_do_oe | output | 1 | Drive enable for the data line |
| ee_di | input | 1 | Incoming value from the data line |

## Verification
The assertions assume that `rst_n` is held low long enough to clear every register. They also assume that `ee_di` is only a data input, so they say nothing about its value. Beyond that, they constrain only the controller's own outputs and its handshake.

The EEPROM model in the bench changes `ee_di` on the falling system-clock edge after each serial rising edge. The line is therefore stable for a whole serial period before the controller samples it. The driver presents requests only on falling system-clock edges. Besides ordinary reads, it deliberately raises a request during a transaction to exercise the hold-off rule.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2,
        ST_GAP  = 2'd3
    } sprom_state_e;

    localparam logic       START_BIT = 1'b1;
    localparam logic [1:0] RD_CODE   = 2'b10;
    localparam int         HDR_W     = 3;

endpackage

// File: rtl/sprom_sclk_gen.sv
module sprom_sclk_gen #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic gate,
    output logic rise_stb,
    output logic fall_stb,
    output logic wrap_stb,
    output logic sclk
);

    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          at_end;
    logic          at_mid;

    assign at_end   = (cnt_q == CW'(DIV - 1));
    assign at_mid   = (cnt_q == CW'(HALF - 1));
    assign rise_stb = run && gate && at_mid;
    assign fall_stb = run && gate && at_end;
    assign wrap_stb = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk <= 1'b0;
        end else if (rise_stb) begin
            sclk <= 1'b1;
        end else if (fall_stb || !gate || !run) begin
            sclk <= 1'b0;
        end
    end

endmodule

// File: rtl/sprom_shift.sv
module sprom_shift #(
    parameter int TX_W = 11,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_val,
    input  logic            tx_shift,
    input  logic            rx_shift,
    input  logic            rx_bit,
    output logic            tx_msb,
    output logic [RX_W-1:0] rx_word
);

    logic [TX_W-1:0] tx_q;

    assign tx_msb = tx_q[TX_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (tx_shift) begin
            tx_q <= {tx_q[TX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (rx_shift) begin
            rx_word <= {rx_word[RX_W-2:0], rx_bit};
        end
    end

endmodule

// File: rtl/sprom_reader.sv
module sprom_reader
    import sprom_pkg::*;
#(
    parameter int DIV    = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              ee_cs,
    output logic              ee_sclk,
    output logic              ee_do,
    output logic              ee_do_oe,
    input  logic              ee_di
);

    localparam int TX_W     = HDR_W + ADDR_W;
    localparam int RISE_TOT = TX_W + 1 + DATA_W;
    localparam int RCW      = $clog2(RISE_TOT + 1);

    sprom_state_e state_q, state_d;

    logic [RCW-1:0]    rise_cnt_q;
    logic              rise_stb, fall_stb, wrap_stb;
    logic              run, gate, load, tx_shift, rx_shift;
    logic              tx_msb;
    logic [DATA_W-1:0] rx_word;
    logic              last_tx_rise, last_rx_rise, capture_rise;

    assign last_tx_rise = (rise_cnt_q == RCW'(TX_W));
    assign last_rx_rise = (rise_cnt_q == RCW'(RISE_TOT));
    assign capture_rise = (rise_cnt_q >= RCW'(TX_W + 1));

    sprom_sclk_gen #(.DIV(DIV)) i_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .gate     (gate),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .wrap_stb (wrap_stb),
        .sclk     (ee_sclk)
    );

    sprom_shift #(.TX_W(TX_W), .RX_W(DATA_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val ({START_BIT, RD_CODE, rd_addr}),
        .tx_shift (tx_shift),
        .rx_shift (rx_shift),
        .rx_bit   (ee_di),
        .tx_msb   (tx_msb),
        .rx_word  (rx_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req)                    state_d = ST_SEND;
            ST_SEND: if (fall_stb && last_tx_rise)  state_d = ST_RECV;
            ST_RECV: if (fall_stb && last_rx_rise)  state_d = ST_GAP;
            ST_GAP:  if (wrap_stb)                  state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        rd_ready = 1'b0;
        ee_cs    = 1'b0;
        ee_do_oe = 1'b0;
        run      = 1'b0;
        gate     = 1'b0;
        load     = 1'b0;
        tx_shift = 1'b0;
        rx_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rd_ready = 1'b1;
                load     = rd_req;
            end
            ST_SEND: begin
                ee_cs    = 1'b1;
                ee_do_oe = 1'b1;
                run      = 1'b1;
                gate     = 1'b1;
                tx_shift = fall_stb && !last_tx_rise;
            end
            ST_RECV: begin
                ee_cs    = 1'b1;
                run      = 1'b1;
                gate     = 1'b1;
                rx_shift = rise_stb && capture_rise;
            end
            ST_GAP: begin
                run      = 1'b1;
            end
            default: begin
                rd_ready = 1'b0;
            end
        endcase
    end

    assign ee_do = tx_msb & ee_do_oe;

    // rising-edge counter for the current transaction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt_q <= '0;
        end else if (state_q == ST_IDLE) begin
            rise_cnt_q <= '0;
        end else if (rise_stb) begin
            rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    // result register and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state_q == ST_RECV) && fall_stb && last_rx_rise;
            if ((state_q == ST_RECV) && fall_stb && last_rx_rise) begin
                rd_data <= rx_word;
            end
        end
    end

endmodule

// File: rtl/sprom_reader_chk.sv
module sprom_reader_chk #(
    parameter int DIV    = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic rd_ready,
    input logic rd_valid,
    input logic ee_cs,
    input logic ee_sclk,
    input logic ee_do,
    input logic ee_do_oe
);

    localparam int RISE_TOT = 3 + ADDR_W + 1 + DATA_W;
    localparam int RCW      = $clog2(RISE_TOT + 2);
    localparam int GW       = $clog2(DIV + 1) + 1;

    logic           sclk_d;
    logic [RCW-1:0] rises;
    logic [GW-1:0]  gap_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            rises   <= '0;
            gap_len <= GW'(DIV);
        end else begin
            sclk_d <= ee_sclk;
            if (!ee_cs) begin
                rises <= '0;
            end else if (ee_sclk && !sclk_d) begin
                rises <= rises + 1'b1;
            end
            if (ee_cs) begin
                gap_len <= '0;
            end else if (gap_len < GW'(DIV)) begin
                gap_len <= gap_len + 1'b1;
            end
        end
    end

    a_r2_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sclk);

    a_r3_select_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sclk) |-> ee_cs);

    a_r4_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_do_oe && $past(ee_do_oe) && $changed(ee_do)) |-> $fell(ee_sclk));

    a_r5_released_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_do_oe);

    a_r5_drive_starts_with_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_do_oe) |-> $rose(ee_cs));

    a_r6_rise_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> (rises == RCW'(RISE_TOT)));

    a_r7_valid_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $fell(ee_cs));

    a_r7_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (gap_len >= GW'(DIV)));

    a_r9_accept_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> $past(rd_ready && rd_req));

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs |-> !rd_ready);

endmodule

bind sprom_reader sprom_reader_chk #(
    .DIV    (DIV),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_sprom_reader_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .ee_cs    (ee_cs),
    .ee_sclk  (ee_sclk),
    .ee_do    (ee_do),
    .ee_do_oe (ee_do_oe)
);

// File: tb/test_sprom_reader.sv
module test_sprom_reader;

    localparam int DIV  = 32;
    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam int TXW  = 3 + AW;
    localparam int RTOT = TXW + 1 + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic          ee_cs, ee_sclk, ee_do, ee_do_oe;
    logic          ee_di = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] exp_q[$];
    logic [AW-1:0] addr_q[$];

    always #5 clk = ~clk;

    sprom_reader #(.DIV(DIV), .ADDR_W(AW), .DATA_W(DW)) i_sprom_reader (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_do(ee_do), .ee_do_oe(ee_do_oe),
        .ee_di(ee_di)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a ^ 8'hC3, ~a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // EEPROM model: looks at the serial pins between system clock edges
    logic           sclk_p = 1'b0, cs_p = 1'b0;
    int             bitpos = 0, cyc = 0, cs_rise_cyc = 0, last_rise_cyc = 0, low_cnt = 0;
    bit             timing_ok = 1'b1, oe_ok = 1'b1, had_txn = 1'b0;
    logic [TXW-1:0] cmd = '0;
    logic [DW-1:0]  word = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ee_cs && !cs_p) begin
                if (had_txn) check(low_cnt >= DIV, "R8", "select low gap", low_cnt, DIV);
                check(ee_do == 1'b1 && ee_do_oe, "R4", "start bit at select", ee_do, 1);
                bitpos = 0; timing_ok = 1'b1; oe_ok = 1'b1; cs_rise_cyc = cyc;
            end
            if (ee_sclk && !sclk_p) begin
                if (!ee_cs) timing_ok = 1'b0;
                if (bitpos == 0) begin
                    if (cyc - cs_rise_cyc != DIV / 2) timing_ok = 1'b0;
                end else if (cyc - last_rise_cyc != DIV) timing_ok = 1'b0;
                last_rise_cyc = cyc;
                if (bitpos < TXW) begin
                    if (!ee_do_oe) oe_ok = 1'b0;
                    cmd = {cmd[TXW-2:0], ee_do};
                end else if (ee_do_oe) oe_ok = 1'b0;
                if (bitpos == TXW - 1) begin
                    word  = mem_word(cmd[AW-1:0]);
                    ee_di = 1'b0;
                end else if (bitpos >= TXW && bitpos < TXW + DW) begin
                    ee_di = word[DW-1-(bitpos-TXW)];
                end
                bitpos++;
            end
            if (!ee_cs && cs_p) begin
                logic [AW-1:0] ea;
                had_txn = 1'b1;
                ea = (addr_q.size() != 0) ? addr_q.pop_front() : '0;
                check(bitpos == RTOT, "R6", "rising edges per read", bitpos, RTOT);
                check(cmd[TXW-1 -: 3] == 3'b110, "R4", "start and read code", cmd[TXW-1 -: 3], 3'b110);
                check(cmd[AW-1:0] == ea, "R4", "address bits", cmd[AW-1:0], ea);
                check(timing_ok, "R2", "serial clock spacing", timing_ok, 1);
                check(oe_ok && !ee_do_oe, "R5", "data line drive window", oe_ok, 1);
                ee_di = 1'b0;
                low_cnt = 0;
            end
            if (!ee_cs) low_cnt++;
        end
        sclk_p = ee_sclk;
        cs_p   = ee_cs;
    end

    // monitor: scoreboard compare
    bit            prev_valid = 1'b0;
    logic [DW-1:0] last_word = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid) check(!rd_valid, "R7", "valid one cycle", rd_valid, 0);
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "result without accepted request", rd_data, 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R6", "read word", rd_data, e);
                    check(!ee_cs, "R7", "valid with select low", ee_cs, 0);
                end
                last_word = rd_data;
            end
            prev_valid = rd_valid;
        end
    end

    task automatic do_read(input logic [AW-1:0] a);
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        rd_addr = a;
        rd_req  = 1'b1;
        exp_q.push_back(mem_word(a));
        addr_q.push_back(a);
        @(negedge clk);
        rd_req  = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || !rd_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!ee_cs && !ee_sclk && !ee_do_oe, "R1", "serial pins in reset", {ee_cs, ee_sclk, ee_do_oe}, 0);
        check(rd_ready && !rd_valid, "R1", "handshake in reset", {rd_ready, rd_valid}, 2);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!ee_cs && !ee_sclk && rd_ready, "R2", "idle pins", {ee_cs, ee_sclk, rd_ready}, 1);

        do_read(8'h00);
        do_read(8'hFF);
        do_read(8'hA5);
        do_read(8'h80);
        do_read(8'h01);
        wait_idle();

        // request while busy must be ignored (R9)
        do_read(8'h3C);
        repeat (100) @(negedge clk);
        check(!rd_ready, "R9", "ready low while busy", rd_ready, 0);
        rd_addr = 8'h77;
        rd_req  = 1'b1;
        repeat (5) @(negedge clk);
        rd_req  = 1'b0;
        wait_idle();
        repeat (3 * DIV) @(negedge clk);
        check(!ee_cs, "R9", "no transaction from busy request", ee_cs, 0);
        check(rd_data == mem_word(8'h3C), "R7", "word held after strobe", rd_data, mem_word(8'h3C));
        check(exp_q.size() == 0, "R9", "all results delivered", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule